// File: doc/BRIEF.md
# Write Status and Polling Generator

This block forms the status word a host reads from a bank that is busy with an internal program or erase, and drives the active-low ready/busy pin. The command decoder pulses `op_start` on the strobe that launches an operation and gives its kind. The internal timing logic holds `op_busy` until the operation is over. Reads aimed at the busy bank are marked by `rd_strobe`. While an operation runs, the host polls two status bits. The polling bit gives the inverse of the data being programmed, or a fixed 0 while erasing. The toggle bit inverts on each read access. An extra toggle bit moves only during erase, so the host can tell an erase from a program.

A four-state machine controls the block. Its states are `ST_IDLE`, `ST_PROG`, `ST_ERASE` and `ST_QUERY`. The accepted start transitions are IDLE to PROG (kind 0), IDLE to ERASE (kind 1) and IDLE to QUERY (kind 2 or 3, an identification or query session). The done transition returns PROG, ERASE or QUERY to IDLE when busy falls. The abort transition returns any state to IDLE while the pin reset is low. Ready/busy is an open-drain output: it drives low only while the machine is out of IDLE, chip enable and output enable are both low, and the pin reset is high. At all other times it releases.

Top module: `ws_status_gen`

## Requirements
- R1: After reset the machine is idle, `stat_word` equals `array_data` and `rb_oe` is 0.
- R2: In ST_PROG, bit 7 of `stat_word` is the inverse of bit 7 of `prog_data` as captured on the accepted start.
- R3: In ST_ERASE, bit 7 of `stat_word` reads 0.
- R4: When `op_busy` falls, the machine returns to IDLE on the next edge and `stat_word` again equals `array_data`, so bit 7 shows true data.
- R5: In PROG or ERASE, bit 6 changes once per cycle that has `rd_strobe` high, and holds in cycles without it. The value read in a strobe cycle is the value from before that read.
- R6: An accepted start clears bit 6 and bit 2 to 0, so the first read of every operation shows 0 in both bits.
- R7: Bit 2 toggles on each read in ST_ERASE and holds at 0 in ST_PROG.
- R8: `rb_oe` is 1 only when the machine is out of IDLE, `ce_n`=0, `oe_n`=0 and `pin_rst_n`=1. `rb_n` is always 0.
- R9: `pin_rst_n` low sends the machine to IDLE on the next edge, whatever the state of `op_busy`.
- R10: `op_start` outside IDLE is ignored: the kind, the captured polling data and the toggle sequence all continue unchanged.
- R11: The bits other than 7, 6 and 2 return `array_data` when FILL_ARRAY=1 (the default), or 0 when FILL_ARRAY=0.
- R12: Changes on `prog_data` after the start do not affect bit 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous system reset, active low |
| pin_rst_n | input | 1 | Device reset pin, active low; aborts operation |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| op_start | input | 1 | One-cycle pulse launching an operation |
| op_kind | input | 2 | 0 program, 1 erase, 2/3 query session |
| op_busy | input | 1 | High while the internal operation lasts |
| prog_data | input | DATA_W | True word being programmed |
| array_data | input | DATA_W | Word read from the array at the read address |
| rd_strobe | input | 1 | One cycle per read access to the busy bank |
| stat_word | output | DATA_W | Word returned to the host |
| rb_n | output | 1 | Ready/busy pin value, constant 0 (open drain) |
| rb_oe | output | 1 | Ready/busy drive enable; 1 pulls the pin low |

## Verification
A table covers programs with data bit 7 set and with it clear, and erases with both values of that bit. Each is read an odd or even number of times. These cases separate a complemented polling bit from a constant one, and show whether bit 2 moves with the kind of operation. Directed runs then separate toggling per read from toggling per clock by idling between reads. They show that a captured polling value is kept after `prog_data` changes or a second start arrives. They also check that ready/busy follows the enables, the pin reset and a query session.

// File: rtl/ws_pkg.sv
package ws_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_PROG  = 2'd1,
        ST_ERASE = 2'd2,
        ST_QUERY = 2'd3
    } ws_state_e;

    localparam logic [1:0] KIND_PROG  = 2'd0;
    localparam logic [1:0] KIND_ERASE = 2'd1;
endpackage

// File: rtl/ws_fsm.sv
module ws_fsm
    import ws_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pin_rst_n,
    input  logic       op_start,
    input  logic [1:0] op_kind,
    input  logic       op_busy,
    output logic       start_acc,
    output logic       run_prog,
    output logic       run_erase,
    output logic       held
);
    ws_state_e state_q, state_nx;

    always_comb begin
        state_nx = state_q;
        if (!pin_rst_n) begin
            state_nx = ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (op_start) begin
                        if (op_kind == KIND_PROG)       state_nx = ST_PROG;
                        else if (op_kind == KIND_ERASE) state_nx = ST_ERASE;
                        else                            state_nx = ST_QUERY;
                    end
                end
                ST_PROG, ST_ERASE, ST_QUERY: begin
                    if (!op_busy) state_nx = ST_IDLE;
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_nx;
    end

    always_comb begin
        start_acc = 1'b0;
        run_prog  = 1'b0;
        run_erase = 1'b0;
        held      = 1'b0;
        unique case (state_q)
            ST_IDLE:  start_acc = op_start & pin_rst_n;
            ST_PROG:  begin run_prog  = 1'b1; held = 1'b1; end
            ST_ERASE: begin run_erase = 1'b1; held = 1'b1; end
            ST_QUERY: held = 1'b1;
        endcase
    end

    p_abort_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !pin_rst_n |=> (state_q == ST_IDLE));

    p_ignore_start_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_IDLE && op_busy && pin_rst_n) |=> (state_q == $past(state_q)));
endmodule

// File: rtl/ws_toggle.sv
module ws_toggle (
    input  logic clk,
    input  logic rst_n,
    input  logic start_acc,
    input  logic run_prog,
    input  logic run_erase,
    input  logic rd_strobe,
    input  logic poll_src,
    output logic poll_latch,
    output logic tog_main,
    output logic tog_alt
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            poll_latch <= 1'b0;
            tog_main   <= 1'b0;
            tog_alt    <= 1'b0;
        end else if (start_acc) begin
            poll_latch <= poll_src;
            tog_main   <= 1'b0;
            tog_alt    <= 1'b0;
        end else if (rd_strobe) begin
            if (run_prog || run_erase) tog_main <= ~tog_main;
            if (run_erase)             tog_alt  <= ~tog_alt;
        end
    end

    p_tog_read_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_strobe && (run_prog || run_erase) && !start_acc) |=> (tog_main != $past(tog_main)));

    p_tog_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_strobe && !start_acc) |=> $stable(tog_main));

    p_tog_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        start_acc |=> (!tog_main && !tog_alt));

    p_alt_prog_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (run_prog && !start_acc) |=> $stable(tog_alt));

    p_latch_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !start_acc |=> $stable(poll_latch));
endmodule

// File: rtl/ws_compose.sv
module ws_compose #(
    parameter int DATA_W     = 16,
    parameter int POLL_BIT   = 7,
    parameter int TOG_BIT    = 6,
    parameter int ALT_BIT    = 2,
    parameter bit FILL_ARRAY = 1'b1
) (
    input  logic              run_prog,
    input  logic              run_erase,
    input  logic [DATA_W-1:0] array_data,
    input  logic              poll_latch,
    input  logic              tog_main,
    input  logic              tog_alt,
    output logic [DATA_W-1:0] stat_word
);
    localparam logic [DATA_W-1:0] STAT_MASK =
        (DATA_W'(1) << POLL_BIT) | (DATA_W'(1) << TOG_BIT) | (DATA_W'(1) << ALT_BIT);

    logic [DATA_W-1:0] base_w;

    generate
        if (FILL_ARRAY) begin : g_fill_array
            assign base_w = array_data & ~STAT_MASK;
        end else begin : g_fill_zero
            assign base_w = '0;
        end
    endgenerate

    always_comb begin
        stat_word = array_data;
        if (run_prog || run_erase) begin
            stat_word           = base_w;
            stat_word[POLL_BIT] = run_prog ? ~poll_latch : 1'b0;
            stat_word[TOG_BIT]  = tog_main;
            stat_word[ALT_BIT]  = tog_alt;
        end
    end

    always_comb begin
        if (run_prog && run_erase) begin
            a_one_kind_r7: assert (1'b0)
                else $error("program and erase both active");
        end
    end
endmodule

// File: rtl/ws_status_gen.sv
module ws_status_gen #(
    parameter int DATA_W     = 16,
    parameter int POLL_BIT   = 7,
    parameter int TOG_BIT    = 6,
    parameter int ALT_BIT    = 2,
    parameter bit FILL_ARRAY = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pin_rst_n,
    input  logic              ce_n,
    input  logic              oe_n,
    input  logic              op_start,
    input  logic [1:0]        op_kind,
    input  logic              op_busy,
    input  logic [DATA_W-1:0] prog_data,
    input  logic [DATA_W-1:0] array_data,
    input  logic              rd_strobe,
    output logic [DATA_W-1:0] stat_word,
    output logic              rb_n,
    output logic              rb_oe
);
    logic start_acc, run_prog, run_erase, held;
    logic poll_latch, tog_main, tog_alt;

    ws_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .pin_rst_n (pin_rst_n),
        .op_start  (op_start),
        .op_kind   (op_kind),
        .op_busy   (op_busy),
        .start_acc (start_acc),
        .run_prog  (run_prog),
        .run_erase (run_erase),
        .held      (held)
    );

    ws_toggle u_tog (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_acc  (start_acc),
        .run_prog   (run_prog),
        .run_erase  (run_erase),
        .rd_strobe  (rd_strobe),
        .poll_src   (prog_data[POLL_BIT]),
        .poll_latch (poll_latch),
        .tog_main   (tog_main),
        .tog_alt    (tog_alt)
    );

    ws_compose #(
        .DATA_W     (DATA_W),
        .POLL_BIT   (POLL_BIT),
        .TOG_BIT    (TOG_BIT),
        .ALT_BIT    (ALT_BIT),
        .FILL_ARRAY (FILL_ARRAY)
    ) u_cmp (
        .run_prog   (run_prog),
        .run_erase  (run_erase),
        .array_data (array_data),
        .poll_latch (poll_latch),
        .tog_main   (tog_main),
        .tog_alt    (tog_alt),
        .stat_word  (stat_word)
    );

    assign rb_n  = 1'b0;
    assign rb_oe = held & ~ce_n & ~oe_n & pin_rst_n;

    p_rb_after_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!op_busy && !op_start) |=> !rb_oe);

    p_done_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!op_busy && !op_start) |=> (stat_word == array_data));
endmodule

// File: tb/ws_status_gen_tb.sv
module ws_status_gen_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pin_rst_n = 1'b1;
    logic        ce_n = 1'b0;
    logic        oe_n = 1'b0;
    logic        op_start = 1'b0;
    logic [1:0]  op_kind = 2'd0;
    logic        op_busy = 1'b0;
    logic [15:0] prog_data = 16'h0000;
    logic [15:0] array_data = 16'h1234;
    logic        rd_strobe = 1'b0;
    logic [15:0] stat_word;
    logic        rb_n, rb_oe;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    localparam logic [15:0] MASK = 16'h00C4;

    // fields: kind[7:6], data bit7 [5], expected polling bit [4], read count [3:0]
    localparam logic [7:0] VEC [4] = '{
        {2'd0, 1'b1, 1'b0, 4'd5},
        {2'd0, 1'b0, 1'b1, 4'd4},
        {2'd1, 1'b1, 1'b0, 4'd6},
        {2'd1, 1'b0, 1'b0, 4'd3}
    };

    always #5 clk = ~clk;

    ws_status_gen dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .pin_rst_n  (pin_rst_n),
        .ce_n       (ce_n),
        .oe_n       (oe_n),
        .op_start   (op_start),
        .op_kind    (op_kind),
        .op_busy    (op_busy),
        .prog_data  (prog_data),
        .array_data (array_data),
        .rd_strobe  (rd_strobe),
        .stat_word  (stat_word),
        .rb_n       (rb_n),
        .rb_oe      (rb_oe)
    );

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic start_op(input logic [1:0] k, input logic [15:0] d);
        @(negedge clk);
        op_start = 1'b1; op_kind = k; prog_data = d; op_busy = 1'b1;
        @(negedge clk);
        op_start = 1'b0;
    endtask

    task automatic rd_chk(input string req, input logic e7, input logic e6, input logic e2);
        @(negedge clk);
        rd_strobe = 1'b1;
        #1;
        chk(req, {13'd0, stat_word[7], stat_word[6], stat_word[2]}, {13'd0, e7, e6, e2});
        chk("R11 other bits", stat_word & ~MASK, array_data & ~MASK);
        @(posedge clk);
        #1 rd_strobe = 1'b0;
    endtask

    task automatic finish_op;
        @(negedge clk);
        op_busy = 1'b0;
        @(negedge clk);
        #1;
        chk("R4 true data after done", stat_word, array_data);
        chk("R8 released after done", {15'd0, rb_oe}, 16'd0);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        #1;
        chk("R1 reset word", stat_word, array_data);
        chk("R1 reset ready", {15'd0, rb_oe}, 16'd0);
        chk("R8 pin constant low", {15'd0, rb_n}, 16'd0);
        @(negedge clk);
        rst_n = 1'b1;

        // table walk: R2 R3 R5 R6 R7
        for (int i = 0; i < 4; i++) begin
            logic [1:0] k;
            k = VEC[i][7:6];
            array_data = 16'hA55A ^ 16'(i * 16'h1111);
            start_op(k, {8'h3C, VEC[i][5], 7'h15});
            #1 chk("R8 busy drives low", {15'd0, rb_oe}, 16'd1);
            for (int j = 0; j < int'(VEC[i][3:0]); j++) begin
                rd_chk(k == 2'd0 ? "R2 R5 R7 program read" : "R3 R5 R7 erase read",
                       VEC[i][4], j[0], (k == 2'd1) ? j[0] : 1'b0);
            end
            finish_op();
        end

        // R5 no clock toggling, R12 data change, R10 second start ignored
        start_op(2'd0, 16'h0000);
        rd_chk("R6 first read zero", 1'b1, 1'b0, 1'b0);
        repeat (5) @(negedge clk);
        prog_data = 16'h0080;
        rd_chk("R5 R12 hold between reads", 1'b1, 1'b1, 1'b0);
        @(negedge clk);
        op_start = 1'b1; op_kind = 2'd1; prog_data = 16'h0080;
        @(negedge clk);
        op_start = 1'b0;
        rd_chk("R10 start ignored", 1'b1, 1'b0, 1'b0);
        // R8 enables
        @(negedge clk); ce_n = 1'b1; #1;
        chk("R8 ce high releases", {15'd0, rb_oe}, 16'd0);
        @(negedge clk); ce_n = 1'b0; oe_n = 1'b1; #1;
        chk("R8 oe high releases", {15'd0, rb_oe}, 16'd0);
        @(negedge clk); oe_n = 1'b0; #1;
        chk("R8 enables low drive", {15'd0, rb_oe}, 16'd1);
        finish_op();

        // R6 clear after odd reads in previous op; R9 abort
        start_op(2'd1, 16'h0000);
        rd_chk("R6 erase first", 1'b0, 1'b0, 1'b0);
        rd_chk("R7 erase second", 1'b0, 1'b1, 1'b1);
        @(negedge clk); pin_rst_n = 1'b0; #1;
        chk("R8 pin reset releases", {15'd0, rb_oe}, 16'd0);
        @(negedge clk); pin_rst_n = 1'b1; #1;
        chk("R9 aborted to idle", stat_word, array_data);
        chk("R9 ready after abort", {15'd0, rb_oe}, 16'd0);
        @(negedge clk); op_busy = 1'b0;

        // query session: busy low pin, true data
        start_op(2'd2, 16'h0000);
        #1;
        chk("R8 query drives low", {15'd0, rb_oe}, 16'd1);
        chk("R4 query word", stat_word, array_data);
        finish_op();

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule